// File: doc/BRIEF.md
# GPIO Output and Direction Control Bank

This block holds the output state and per-line configuration of a bank of general-purpose I/O lines. It drives each pad's output value and output enable, and it returns pad inputs through a two-flop synchronizer. Software does not write the output data word directly. It writes a mask to a set port or to a clear port, so one agent can change some lines without disturbing lines owned by another agent. Every line has a configuration word with these controls:

- output enable
- polarity inversion, applied both to the driven value and to the value read back
- open-drain drive
- a function-select field that hands the pad to another function and locks out GPIO writes to that line

The register port takes one request per cycle and has no back-pressure. Every request presented with `bus_valid` high is accepted in that cycle. A read returns its data on `bus_rdata` with `bus_rvalid` high exactly one cycle later. Writes take effect at the clock edge that accepts them.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every `pad_out` and `pad_oe` bit is 0. Reads of the output data and of every configuration word return 0.
- R2: A write to a bank's set port (bank base + 0x08) makes each stored output bit at a 1 position of the write data equal 1. Bits written as 0 keep their value.
- R3: A write to a bank's clear port (bank base + 0x10) makes each stored output bit at a 1 position equal 0. Bits written as 0 keep their value.
- R4: Bank b starts at address b*0x1400. Bit i of each bank register is line 64*b+i. Reading the set or clear port returns the stored output data. Bits of lines that do not exist read 0 and cannot be set.
- R5: Line n's configuration word is at 0x400 + 8*n. Bit 0 is output enable, bit 1 is inversion, bit 12 is open-drain, and bits 25:16 are function select. Readback returns only these fields, and all other bits read 0.
- R6: While a line's function select is nonzero, set and clear writes leave its stored bit unchanged, and its `pad_out` and `pad_oe` are 0.
- R7: In push-pull mode (open-drain 0), `pad_oe` equals the output enable and `pad_out` equals the stored bit XOR inversion.
- R8: In open-drain mode, `pad_out` is 0. `pad_oe` is 1 only when output enable is 1 and the stored bit XOR inversion is 0.
- R9: The input data register (bank base + 0x00) returns each pad input after two synchronizer flops, XORed with that line's inversion bit, whatever the line's direction.
- R10: A read gives `bus_rvalid` and `bus_rdata` exactly one cycle after the request. A write gives no `bus_rvalid`. Writes to the read-only input data address or to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Request present; always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 64 | Read data |
| pad_in | input | NUM_LINES | Raw pad inputs |
| pad_out | output | NUM_LINES | Pad output value |
| pad_oe | output | NUM_LINES | Pad output enable |

## Verification
The bench writes masks that mix 1 and 0 bits to the set and clear ports. A design that overwrote the whole word, instead of merging the mask into the stored value, would lose bits that were written as 0.

It reaches lines in the second bank and writes all ones there, to catch a bank decode that is misplaced and to catch storage bits for lines that do not exist. It writes all ones to a configuration word to catch readback of reserved bits.

It hands a line to another function and then tries to set it, which catches a lock-out that is missing. It runs a line in open-drain mode with the stored bit at both values, and it inverts an input line. A design that drove a high level in open-drain mode, or returned the raw pad value, would be caught there.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int WORD_W     = 64;
  localparam int FSEL_W     = 10;
  localparam int BIT_OE     = 0;
  localparam int BIT_INV    = 1;
  localparam int BIT_OD     = 12;
  localparam int FSEL_LSB   = 16;

  typedef struct packed {
    logic [FSEL_W-1:0] fsel;
    logic              od;
    logic              inv;
    logic              oe;
  } line_cfg_t;

  function automatic line_cfg_t cfg_unpack(input logic [WORD_W-1:0] w);
    line_cfg_t c;
    c.oe   = w[BIT_OE];
    c.inv  = w[BIT_INV];
    c.od   = w[BIT_OD];
    c.fsel = w[FSEL_LSB +: FSEL_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_pack(input line_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BIT_OE]              = c.oe;
    w[BIT_INV]             = c.inv;
    w[BIT_OD]              = c.od;
    w[FSEL_LSB +: FSEL_W]  = c.fsel;
    return w;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive (
  input  logic dout,
  input  logic inv,
  input  logic oe,
  input  logic od,
  input  logic owned,
  output logic pad_out,
  output logic pad_oe
);
  logic level;

  always_comb begin
    level = dout ^ inv;
    if (owned) begin
      pad_out = 1'b0;
      pad_oe  = 1'b0;
    end else if (od) begin
      pad_out = 1'b0;
      pad_oe  = oe & ~level;
    end else begin
      pad_out = level;
      pad_oe  = oe;
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES   = 72,
  parameter int ADDR_W      = 16,
  parameter int BANK_STRIDE = 'h1400,
  parameter int OFS_RX      = 'h00,
  parameter int OFS_SET     = 'h08,
  parameter int OFS_CLR     = 'h10,
  parameter int CFG_BASE    = 'h400
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic                 bus_rvalid,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe
);
  localparam int NBANK = (NUM_LINES + WORD_W - 1) / WORD_W;
  localparam int PADW  = NBANK * WORD_W;
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  line_cfg_t         cfg_q [NUM_LINES];
  logic [PADW-1:0]   dout_q;
  logic [PADW-1:0]   set_vec, clr_vec, rx_vec, inv_vec;
  logic [NUM_LINES-1:0] sync_in;
  logic [NBANK-1:0]  rx_hit, set_hit, clr_hit;
  logic [ADDR_W-1:0] cfg_off;
  logic [IDX_W-1:0]  cfg_idx;
  logic              cfg_hit, cfg_we;
  logic [WORD_W-1:0] rdata_n;

  // Address decode
  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      rx_hit[b]  = (bus_addr == ADDR_W'(BANK_STRIDE * b + OFS_RX));
      set_hit[b] = (bus_addr == ADDR_W'(BANK_STRIDE * b + OFS_SET));
      clr_hit[b] = (bus_addr == ADDR_W'(BANK_STRIDE * b + OFS_CLR));
    end
    cfg_off = bus_addr - ADDR_W'(CFG_BASE);
    cfg_idx = cfg_off[3 +: IDX_W];
    cfg_hit = (bus_addr >= ADDR_W'(CFG_BASE)) &&
              (cfg_off < ADDR_W'(8 * NUM_LINES)) && (cfg_off[2:0] == 3'd0);
    cfg_we  = bus_valid && bus_write && cfg_hit;
  end

  // Set and clear masks spread over all banks
  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bus_valid && bus_write && set_hit[b]) set_vec[b*WORD_W +: WORD_W] = bus_wdata;
      if (bus_valid && bus_write && clr_hit[b]) clr_vec[b*WORD_W +: WORD_W] = bus_wdata;
    end
  end

  gpio_sync2 #(.W(NUM_LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (sync_in)
  );

  always_comb begin
    rx_vec  = '0;
    inv_vec = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      inv_vec[i] = cfg_q[i].inv;
      rx_vec[i]  = sync_in[i] ^ cfg_q[i].inv;
    end
  end

  // Stored bits of lines that do not exist stay 0
  if (PADW > NUM_LINES) begin : g_pad_tail
    always_ff @(posedge clk) dout_q[PADW-1:NUM_LINES] <= '0;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic owned;
    assign owned = |cfg_q[i].fsel;

    always_ff @(posedge clk) begin
      if (rst) begin
        dout_q[i] <= 1'b0;
      end else if (!owned) begin
        if (set_vec[i])      dout_q[i] <= 1'b1;
        else if (clr_vec[i]) dout_q[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                                    cfg_q[i] <= '0;
      else if (cfg_we && (int'(cfg_idx) == i))    cfg_q[i] <= cfg_unpack(bus_wdata);
    end

    gpio_pad_drive u_drive (
      .dout    (dout_q[i]),
      .inv     (cfg_q[i].inv),
      .oe      (cfg_q[i].oe),
      .od      (cfg_q[i].od),
      .owned   (owned),
      .pad_out (pad_out[i]),
      .pad_oe  (pad_oe[i])
    );

    // R2: a set write to an unowned line leaves the bit at 1
    a_r2_set_takes: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && bus_write && set_vec[i] && !owned) |=> dout_q[i]);
    // R6: an owned line keeps its stored bit and drives nothing
    a_r6_owned_hold: assert property (@(posedge clk) disable iff (rst)
      owned |=> $stable(dout_q[i]));
    a_r6_owned_quiet: assert property (@(posedge clk) disable iff (rst)
      owned |-> (!pad_oe[i] && !pad_out[i]));
    // R8: open-drain never drives a high level
    a_r8_od_no_high: assert property (@(posedge clk) disable iff (rst)
      cfg_q[i].od |-> !pad_out[i]);
  end

  // Read mux, registered: data one cycle after request
  always_comb begin
    rdata_n = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (rx_hit[b])                rdata_n = rx_vec[b*WORD_W +: WORD_W];
      if (set_hit[b] || clr_hit[b]) rdata_n = dout_q[b*WORD_W +: WORD_W];
    end
    if (cfg_hit) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (int'(cfg_idx) == i) rdata_n = cfg_pack(cfg_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      bus_rdata  <= (bus_valid && !bus_write) ? rdata_n : '0;
    end
  end

  // R10: a response only follows a read request
  a_r10_rvalid_from_read: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_valid && !bus_write));

  logic unused_inv;
  assign unused_inv = ^inv_vec;
endmodule

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 72;

  logic        clk = 0;
  logic        rst = 1;
  logic        bus_valid = 0, bus_write = 0;
  logic [15:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [63:0] bus_rdata;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctrl u_gpio_bank_ctrl (
    .clk, .rst, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
    .bus_rvalid, .bus_rdata, .pad_in, .pad_out, .pad_oe
  );

  typedef struct packed {
    logic        rd;
    logic [15:0] addr;
    logic [63:0] data;   // write data or expected read data
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 16'h0008, 64'h0000_0000_0000_00F5},  // R2 set
    '{1'b1, 16'h0008, 64'h0000_0000_0000_00F5},
    '{1'b0, 16'h0010, 64'h0000_0000_0000_0005},  // R3 clear
    '{1'b1, 16'h0010, 64'h0000_0000_0000_00F0},
    '{1'b0, 16'h1408, 64'hFFFF_FFFF_FFFF_FFFF},  // R4 second bank
    '{1'b1, 16'h1408, 64'h0000_0000_0000_00FF},
    '{1'b0, 16'h0418, 64'hFFFF_FFFF_FFFF_FFFF},  // R5 line 3 config
    '{1'b1, 16'h0418, 64'h0000_0000_03FF_1003},
    '{1'b0, 16'h0418, 64'h0000_0000_0001_0000},  // R6 line 3 owned
    '{1'b0, 16'h0008, 64'h0000_0000_0000_0008},
    '{1'b1, 16'h0008, 64'h0000_0000_0000_00F0},
    '{1'b0, 16'h0418, 64'h0000_0000_0000_0000},  // release line 3
    '{1'b0, 16'h0008, 64'h0000_0000_0000_0008},
    '{1'b1, 16'h0008, 64'h0000_0000_0000_00F8}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [63:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  initial begin
    logic [63:0] rd;
    logic        rv;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1 pad_out", {56'd0, pad_out[7:0]} | 64'(|pad_out), 64'd0);
    check("R1 pad_oe", 64'(|pad_oe), 64'd0);
    bus_rd(16'h0008, rd, rv); check("R1 dout", rd, 64'd0);
    bus_rd(16'h0400, rd, rv); check("R1 cfg0", rd, 64'd0);

    for (int k = 0; k < NV; k++) begin
      if (TBL[k].rd) begin
        bus_rd(TBL[k].addr, rd, rv);
        check($sformatf("R2/R3/R4/R5/R6 vec%0d", k), rd, TBL[k].data);
      end else begin
        bus_wr(TBL[k].addr, TBL[k].data);
      end
    end

    // R10 write to read-only input address and unmapped address
    bus_wr(16'h0000, 64'hFFFF);
    bus_wr(16'h0020, 64'hFFFF);
    bus_rd(16'h0008, rd, rv);
    check("R10 ignored write", rd, 64'h00F8);
    check("R10 rvalid on read", 64'(rv), 64'd1);
    @(negedge clk);
    check("R10 no rvalid idle", 64'(bus_rvalid), 64'd0);

    // R7 push-pull on line 0
    bus_wr(16'h0400, 64'h1);
    bus_wr(16'h0008, 64'h1);
    check("R7 pp out", 64'({pad_oe[0], pad_out[0]}), 64'd3);
    bus_wr(16'h0400, 64'h3);
    check("R7 pp inverted", 64'({pad_oe[0], pad_out[0]}), 64'd2);

    // R8 open-drain on line 4 (stored 1)
    bus_wr(16'h0420, 64'h1001);
    check("R8 od release", 64'({pad_oe[4], pad_out[4]}), 64'd0);
    bus_wr(16'h0010, 64'h10);
    check("R8 od drive low", 64'({pad_oe[4], pad_out[4]}), 64'd2);

    // R6 owned line 5 (stored 1) with oe
    bus_wr(16'h0428, 64'h0001_0001);
    check("R6 owned pad", 64'({pad_oe[5], pad_out[5]}), 64'd0);

    // R9 input path on line 70 (bank 1 bit 6) and line 2 as output
    @(negedge clk); pad_in[70] = 1; pad_in[2] = 1;
    repeat (3) @(negedge clk);
    bus_rd(16'h1400, rd, rv); check("R9 in line70", 64'(rd[6]), 64'd1);
    bus_wr(16'h0630, 64'h2);
    bus_rd(16'h1400, rd, rv); check("R9 in inverted", 64'(rd[6]), 64'd0);
    bus_wr(16'h0410, 64'h1);
    bus_rd(16'h0000, rd, rv); check("R9 in on output", 64'(rd[2]), 64'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule